// File: doc/BRIEF.md
# Privileged Instruction Access Checker

This block sits beside the execute stage of a processor core and rules on each system-control instruction after it has been decoded. It compares the instruction's class against the current privilege level. A permitted instruction takes effect: it updates the global interrupt-enable bit of the interrupt-control register, hands a core-register write to the register file, or simply completes. An instruction that is not permitted, or that does not exist in the configured architecture version, raises a trap instead. The trap carries a class and an identification number. Every result appears in the clock cycle after the instruction is presented on `op_valid`.

Three privilege levels are recognised. The intermediate user level 1 may change the interrupt-enable bit but may not write core registers. When software writes the status word at core offset 0xFE04, the privilege bits in the written data govern the very next instruction. This closes the one-cycle gap before the external status register shows the new value. The architecture-version strap selects where the enable bit sits and whether the value-returning disable exists.

Top module: `priv_sysctl_gate`

## Requirements
- R1: While reset is active, and in the first cycle after it, all outputs are zero, including `icr_q`.
- R2: The privilege level is decoded from `psw_priv` (status bits 11:10) as 0 = user mode 0, 1 = user mode 1, 2 = supervisor. Encoding 3 is given no right at all. Results appear one cycle after `op_valid` is sampled with the instruction.
- R3: Class 1 (core-register write) is performed only in supervisor mode. It then pulses `reg_wr_valid` with `csr_offset` and `src_data` as address and data. In any other level it traps with class 1 (protection) and identification number 1.
- R4: A permitted core-register write to offset 0xFE04 also pulses `psw_wr_valid`. For the instruction in the following cycle only, the privilege level is taken from `src_data[11:10]` instead of `psw_priv`.
- R5: Classes 2 (disable), 4 (enable) and 5 (restore) are permitted in supervisor mode and in user mode 1. Disable clears the enable bit, enable sets it, and restore writes `src_data[0]` into it. In user mode 0 or encoding 3 they trap with class 1 and number 1.
- R6: Class 3 (disable with result) under version 0 traps with class 2 (illegal opcode) and number 1. Otherwise it follows the privilege rule of R5. When permitted, it pulses `dst_valid` with the old enable bit zero-extended and clears the bit.
- R7: The enable bit is bit 15 of `icr_q` when `arch_ver` is 2 or 3, and bit 8 when `arch_ver` is 0 or 1.
- R8: Classes 6 (begin service) and 7 (return from monitor) complete with an `op_done` pulse in supervisor mode only. In any other level they trap with class 1 and number 1.
- R9: Class 8 (system call) always traps with class 6 and identification number `sys_imm`.
- R10: A trapped instruction leaves `icr_q` unchanged and pulses none of `dst_valid`, `reg_wr_valid` and `op_done`. `trap_valid` is high for exactly one cycle per trapping instruction.
- R11: Class 0, and any instruction presented with `op_valid` low, has no effect. Classes 9 to 15 trap with class 2 and number 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A decoded instruction is presented this cycle |
| op_class | input | 4 | Encoded instruction class (see R3 to R11) |
| psw_priv | input | 2 | Privilege bits 11:10 of the status word |
| arch_ver | input | 2 | Architecture version: 0 = 1.3, 1 = 1.6, 2/3 = 1.6.1 and later |
| src_data | input | 32 | Source data operand |
| sys_imm | input | 8 | Low 8 bits of the system-call immediate |
| csr_offset | input | 16 | Core-register offset for class 1 |
| icr_q | output | 32 | Interrupt-control register |
| dst_valid | output | 1 | Destination value valid pulse |
| dst_data | output | 32 | Destination value (old enable bit) |
| reg_wr_valid | output | 1 | Core-register write request pulse |
| reg_wr_addr | output | 16 | Core-register write offset |
| reg_wr_data | output | 32 | Core-register write data |
| psw_wr_valid | output | 1 | The write request targets the status word |
| op_done | output | 1 | Instruction completed without trap |
| trap_valid | output | 1 | Trap strobe |
| trap_class | output | 3 | Trap class |
| trap_tin | output | 8 | Trap identification number |

## Verification
The assertions check on every cycle that a trap never coincides with a completion, a register write or a destination value. They check that `icr_q` does not move under a trap and changes at most one bit per cycle. They also check that a status-word request always comes with a write to 0xFE04, and that any register write was granted at supervisor level. Only the bench's scenarios can show the class-by-level permission matrix and the enable-bit position under each version. The same holds for the trap identification numbers and for the one-cycle privilege forwarding after a status-word write, which needs back-to-back instructions.

// File: rtl/priv_sysctl_gate.sv
module priv_sysctl_gate #(
  parameter int DATA_W = 32,
  parameter int ICR_W = 32,
  parameter int ADDR_W = 16,
  parameter int IE_POS_NEW = 15,
  parameter int IE_POS_OLD = 8,
  parameter logic [ADDR_W-1:0] PSW_ADDR = 16'hFE04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_class,
  input  logic [1:0]        psw_priv,
  input  logic [1:0]        arch_ver,
  input  logic [DATA_W-1:0] src_data,
  input  logic [7:0]        sys_imm,
  input  logic [ADDR_W-1:0] csr_offset,
  output logic [ICR_W-1:0]  icr_q,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data,
  output logic              reg_wr_valid,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic              psw_wr_valid,
  output logic              op_done,
  output logic              trap_valid,
  output logic [2:0]        trap_class,
  output logic [7:0]        trap_tin
);
  localparam logic [1:0] LVL_UM1 = 2'd1, LVL_SUP = 2'd2;
  localparam logic [3:0] OP_NOP = 4'd0, OP_MTCR = 4'd1, OP_DIS = 4'd2, OP_DISD = 4'd3,
                         OP_ENA = 4'd4, OP_RST = 4'd5, OP_BISR = 4'd6, OP_RFM = 4'd7,
                         OP_SYSC = 4'd8;
  localparam logic [2:0] TC_PROT = 3'd1, TC_OPC = 3'd2, TC_SYS = 3'd6;
  localparam logic [7:0] TIN_PRIV = 8'd1, TIN_OPC = 8'd1;

  logic       fwd_v;
  logic [1:0] fwd_lvl;

  wire [1:0] lvl    = fwd_v ? fwd_lvl : psw_priv;
  wire       is_sup = (lvl == LVL_SUP);
  wire       ie_ok  = is_sup || (lvl == LVL_UM1);
  wire       newpos = arch_ver[1];
  wire       old_ie = newpos ? icr_q[IE_POS_NEW] : icr_q[IE_POS_OLD];

  logic             trap_n, done_n, dstv_n, wr_n, pswwr_n, ie_wr, ie_val;
  logic [2:0]       cls_n;
  logic [7:0]       tin_n;
  logic [ICR_W-1:0] icr_n;

  always_comb begin
    trap_n = 1'b0; done_n = 1'b0; dstv_n = 1'b0; wr_n = 1'b0; pswwr_n = 1'b0;
    cls_n = 3'd0; tin_n = 8'd0; ie_wr = 1'b0; ie_val = 1'b0;
    if (op_valid) begin
      case (op_class)
        OP_NOP: ;
        OP_MTCR: if (is_sup) begin
            wr_n = 1'b1; pswwr_n = (csr_offset == PSW_ADDR); done_n = 1'b1;
          end else begin trap_n = 1'b1; cls_n = TC_PROT; tin_n = TIN_PRIV; end
        OP_DIS, OP_ENA, OP_RST: if (ie_ok) begin
            ie_wr = 1'b1; done_n = 1'b1;
            ie_val = (op_class == OP_ENA) || (op_class == OP_RST && src_data[0]);
          end else begin trap_n = 1'b1; cls_n = TC_PROT; tin_n = TIN_PRIV; end
        OP_DISD: if (arch_ver == 2'd0) begin
            trap_n = 1'b1; cls_n = TC_OPC; tin_n = TIN_OPC;
          end else if (ie_ok) begin
            ie_wr = 1'b1; dstv_n = 1'b1; done_n = 1'b1;
          end else begin trap_n = 1'b1; cls_n = TC_PROT; tin_n = TIN_PRIV; end
        OP_BISR, OP_RFM: if (is_sup) done_n = 1'b1;
          else begin trap_n = 1'b1; cls_n = TC_PROT; tin_n = TIN_PRIV; end
        OP_SYSC: begin trap_n = 1'b1; cls_n = TC_SYS; tin_n = sys_imm; end
        default: begin trap_n = 1'b1; cls_n = TC_OPC; tin_n = TIN_OPC; end
      endcase
    end
    icr_n = icr_q;
    if (ie_wr) begin
      if (newpos) icr_n[IE_POS_NEW] = ie_val;
      else icr_n[IE_POS_OLD] = ie_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icr_q <= '0; dst_valid <= 1'b0; dst_data <= '0;
      reg_wr_valid <= 1'b0; reg_wr_addr <= '0; reg_wr_data <= '0;
      psw_wr_valid <= 1'b0; op_done <= 1'b0;
      trap_valid <= 1'b0; trap_class <= '0; trap_tin <= '0;
      fwd_v <= 1'b0; fwd_lvl <= '0;
    end else begin
      icr_q        <= icr_n;
      dst_valid    <= dstv_n;
      dst_data     <= dstv_n ? {{(DATA_W-1){1'b0}}, old_ie} : '0;
      reg_wr_valid <= wr_n;
      reg_wr_addr  <= wr_n ? csr_offset : '0;
      reg_wr_data  <= wr_n ? src_data : '0;
      psw_wr_valid <= pswwr_n;
      op_done      <= done_n;
      trap_valid   <= trap_n;
      trap_class   <= cls_n;
      trap_tin     <= tin_n;
      fwd_v        <= pswwr_n;
      fwd_lvl      <= src_data[11:10];
    end
  end

  assert_trap_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (!op_done && !dst_valid && !reg_wr_valid));
  assert_trap_icr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> $stable(icr_q));
  assert_one_bit_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(icr_q ^ $past(icr_q)) <= 1);
  assert_psw_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    psw_wr_valid |-> (reg_wr_valid && reg_wr_addr == PSW_ADDR));
  assert_wr_sup_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid |-> $past(lvl == LVL_SUP));
  assert_dst_zext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |-> (dst_data[DATA_W-1:1] == '0 && op_done));
endmodule

// File: tb/priv_sysctl_gate_tb_top.sv
`timescale 1ns/1ps
module priv_sysctl_gate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [3:0] op_class = '0;
  logic [1:0] psw_priv = '0, arch_ver = '0;
  logic [31:0] src_data = '0;
  logic [7:0] sys_imm = '0;
  logic [15:0] csr_offset = '0;
  logic [31:0] icr_q, dst_data, reg_wr_data;
  logic [15:0] reg_wr_addr;
  logic dst_valid, reg_wr_valid, psw_wr_valid, op_done, trap_valid;
  logic [2:0] trap_class;
  logic [7:0] trap_tin;

  priv_sysctl_gate dut_i (.*);

  always #10 clk = ~clk;

  int nvec = 0, nbad = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [3:0] cls; logic [1:0] prv; logic [1:0] ver; logic [31:0] src; logic [7:0] imm;
    logic trap; logic [2:0] tcl; logic [7:0] tin; logic [31:0] icr; logic dv; logic [31:0] dst;
    logic done;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'd4, 2'd2, 2'd2, 32'h0,        8'h00, 1'b0, 3'd0, 8'd0,  32'h8000, 1'b0, 32'h0, 1'b1}, // R5 R7 enable sup
    '{4'd3, 2'd1, 2'd2, 32'h0,        8'h00, 1'b0, 3'd0, 8'd0,  32'h0,    1'b1, 32'h1, 1'b1}, // R6 disable-d um1
    '{4'd4, 2'd0, 2'd2, 32'h0,        8'h00, 1'b1, 3'd1, 8'd1,  32'h0,    1'b0, 32'h0, 1'b0}, // R5 um0 trap
    '{4'd5, 2'd1, 2'd0, 32'h1,        8'h00, 1'b0, 3'd0, 8'd0,  32'h100,  1'b0, 32'h0, 1'b1}, // R7 restore v1.3
    '{4'd3, 2'd2, 2'd0, 32'h0,        8'h00, 1'b1, 3'd2, 8'd1,  32'h100,  1'b0, 32'h0, 1'b0}, // R6 no disable-d in v1.3
    '{4'd3, 2'd2, 2'd1, 32'h0,        8'h00, 1'b0, 3'd0, 8'd0,  32'h0,    1'b1, 32'h1, 1'b1}, // R6 R7 v1.6 low pos
    '{4'd5, 2'd2, 2'd2, 32'hFFFFFFFF, 8'h00, 1'b0, 3'd0, 8'd0,  32'h8000, 1'b0, 32'h0, 1'b1}, // R5 restore bit0 only
    '{4'd2, 2'd1, 2'd2, 32'h0,        8'h00, 1'b0, 3'd0, 8'd0,  32'h0,    1'b0, 32'h0, 1'b1}, // R5 disable um1
    '{4'd6, 2'd1, 2'd2, 32'h0,        8'h00, 1'b1, 3'd1, 8'd1,  32'h0,    1'b0, 32'h0, 1'b0}, // R8 bisr um1 trap
    '{4'd7, 2'd2, 2'd2, 32'h0,        8'h00, 1'b0, 3'd0, 8'd0,  32'h0,    1'b0, 32'h0, 1'b1}, // R8 rfm sup
    '{4'd8, 2'd2, 2'd2, 32'h0,        8'hA5, 1'b1, 3'd6, 8'hA5, 32'h0,    1'b0, 32'h0, 1'b0}, // R9 syscall
    '{4'd1, 2'd1, 2'd2, 32'h5,        8'h00, 1'b1, 3'd1, 8'd1,  32'h0,    1'b0, 32'h0, 1'b0}, // R3 mtcr um1 trap
    '{4'd4, 2'd3, 2'd2, 32'h0,        8'h00, 1'b1, 3'd1, 8'd1,  32'h0,    1'b0, 32'h0, 1'b0}, // R2 level 3 trap
    '{4'd12,2'd2, 2'd2, 32'h0,        8'h00, 1'b1, 3'd2, 8'd1,  32'h0,    1'b0, 32'h0, 1'b0}, // R11 undefined class
    '{4'd5, 2'd0, 2'd2, 32'h1,        8'h00, 1'b1, 3'd1, 8'd1,  32'h0,    1'b0, 32'h0, 1'b0}  // R10 trapped restore
  };

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [1:0] p, input logic [1:0] v,
                       input logic [31:0] s, input logic [7:0] im, input logic [15:0] off);
    op_valid = 1'b1; op_class = c; psw_priv = p; arch_ver = v; src_data = s; sys_imm = im; csr_offset = off;
    @(negedge clk);
  endtask

  task automatic idle;
    op_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "trap_valid in reset", {31'd0, trap_valid}, 32'd0);
    chk("R1", "icr in reset", icr_q, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after reset", {icr_q[15:0], 10'd0, dst_valid, reg_wr_valid, psw_wr_valid, op_done, trap_valid, 1'b0}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].cls, VECS[i].prv, VECS[i].ver, VECS[i].src, VECS[i].imm, 16'h0010);
      chk("R2 R5 R6 R7 R8 R9 R10 R11 vector", "trap_valid", {31'd0, trap_valid}, {31'd0, VECS[i].trap});
      chk("R9 R10 vector", "trap_class", {29'd0, trap_class}, {29'd0, VECS[i].tcl});
      chk("R9 R10 vector", "trap_tin", {24'd0, trap_tin}, {24'd0, VECS[i].tin});
      chk("R5 R7 R10 vector", "icr", icr_q, VECS[i].icr);
      chk("R6 vector", "dst_valid", {31'd0, dst_valid}, {31'd0, VECS[i].dv});
      chk("R6 vector", "dst_data", dst_data, VECS[i].dst);
      chk("R8 R10 vector", "op_done", {31'd0, op_done}, {31'd0, VECS[i].done});
    end

    idle();
    chk("R10", "trap pulse single cycle", {31'd0, trap_valid}, 32'd0);
    op_class = 4'd4; psw_priv = 2'd2; arch_ver = 2'd2;
    @(negedge clk);
    chk("R11", "op_valid low ignored icr", icr_q, 32'd0);
    chk("R11", "op_valid low ignored done", {31'd0, op_done}, 32'd0);

    apply(4'd1, 2'd2, 2'd2, 32'hDEADBEEF, 8'h00, 16'h0100);
    chk("R3", "reg_wr_valid", {31'd0, reg_wr_valid}, 32'd1);
    chk("R3", "reg_wr_addr", {16'd0, reg_wr_addr}, 32'h0100);
    chk("R3", "reg_wr_data", reg_wr_data, 32'hDEADBEEF);
    chk("R4", "psw_wr_valid other offset", {31'd0, psw_wr_valid}, 32'd0);

    apply(4'd1, 2'd2, 2'd2, 32'h00000000, 8'h00, 16'hFE04);
    chk("R4", "psw_wr_valid", {31'd0, psw_wr_valid}, 32'd1);
    apply(4'd4, 2'd2, 2'd2, 32'h0, 8'h00, 16'h0);
    chk("R4", "forwarded um0 traps enable", {31'd0, trap_valid}, 32'd1);
    chk("R4", "icr held under forwarded trap", icr_q, 32'd0);
    idle();
    apply(4'd4, 2'd2, 2'd2, 32'h0, 8'h00, 16'h0);
    chk("R4", "forward expired, enable done", {31'd0, op_done}, 32'd1);
    chk("R4", "icr enabled", icr_q, 32'h8000);

    apply(4'd1, 2'd2, 2'd2, 32'h00000400, 8'h00, 16'hFE04);
    apply(4'd2, 2'd0, 2'd2, 32'h0, 8'h00, 16'h0);
    chk("R4", "forwarded um1 allows disable", {31'd0, trap_valid}, 32'd0);
    chk("R4", "disable cleared bit", icr_q, 32'd0);

    apply(4'd0, 2'd2, 2'd2, 32'hFFFFFFFF, 8'h00, 16'hFE04);
    chk("R11", "class 0 no write", {31'd0, reg_wr_valid}, 32'd0);
    chk("R11", "class 0 no trap/done", {30'd0, trap_valid, op_done}, 32'd0);
    idle();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule